// File: doc/BRIEF.md
# Reloading Tick Timer

This block is a periodic down-counter for an operating system tick. Software chooses a 24-bit reload value, selects the count source and enables the counter through a small word-addressed register interface. On every enabled tick the counter either decrements or, when it already sits at zero, takes the reload value again. The step from 1 to 0 is the event. It sets a sticky count flag and, when interrupts are enabled, raises a level request towards the interrupt controller.

Because the event comes from the 1-to-0 step and not from the wrap, a reload of N-1 gives one event every N ticks, and a reload of zero never produces an event. Reading the control/status word returns the flag and clears it. Writing any value to the current-value word sends the counter to zero and clears the flag, so the period restarts on the next tick. A separate input stalls counting, for example while a debugger holds the core. A read-only calibration word reports a 10 ms count and two quality bits that are fixed at build time.

Register word offsets: 0 control/status, 1 reload, 2 current value, 3 calibration. Control/status bits: bit 0 run, bit 1 interrupt enable, bit 2 count source (1 = every core clock, 0 = only cycles with the reference enable high), bit 16 count flag (read-only).

Top module: `reload_tick_timer`

## Requirements
- R1: After reset the control/status, reload and current-value words all read 0 and `irq_req` is low.
- R2: The reload word keeps 24 bits. Bits 31:24 are ignored on write and read as 0.
- R3: On each enabled tick, a counter at 0 loads the reload value and any other value decrements by one. A reload of N-1 therefore repeats the sequence with period N.
- R4: The step of the counter from 1 to 0 sets the count flag (bit 16). `irq_req` is high whenever the flag is set and the interrupt enable (bit 1) is set, and is low otherwise.
- R5: With a reload of 0 the counter stays at 0, and neither the flag nor `irq_req` is ever raised.
- R6: A read of the control/status word returns the flag as it stood, then clears it. An event in the same cycle as the read wins.
- R7: A write of any value to the current-value word sets the counter to 0 and clears the flag, without producing an event.
- R8: With bit 2 = 0 the counter advances only in cycles where `ref_tick_en` is high. With bit 2 = 1 it advances in every cycle.
- R9: While `halt_req` is high the counter holds its value. Counting resumes on the first cycle after release.
- R10: The calibration word is read-only and reads {no-reference bit at 31, skew bit at 30, zeros at 29:24, 10 ms count at 23:0}, built from parameters. Writes to it have no effect.
- R11: Bit 16 of a control/status write is ignored: writing 1 there does not set the flag. Other bits above 2 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick_en | input | 1 | Reference count enable, one core-clock cycle per reference tick |
| halt_req | input | 1 | Stalls counting while high |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle, 0 otherwise |
| irq_req | output | 1 | Level interrupt request |

## Verification
The bench reads the current value in every cycle across several periods. An off-by-one in the reload path, such as firing on the wrap or loading N, would shift the whole sequence and break the period of N. It programs a zero reload and leaves the counter running; a design that fired on wrap or underflow would raise the flag there. It reads the control/status word twice in a row to show the flag is cleared by the read and not by the write path. It writes the current value just after an event to show that the flag is dropped and that no spurious event follows. Finally, it holds the reference enable low and then pulses it, and raises the stall input. A design that ignored either would move the counter where the bench expects it frozen.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_CTRL    = 2'd0,
    RA_RELOAD  = 2'd1,
    RA_CURRENT = 2'd2,
    RA_CALIB   = 2'd3
  } reg_addr_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 16;
  localparam int CAL_SKEW_BIT  = 30;
  localparam int CAL_NOREF_BIT = 31;

  typedef struct packed {
    logic src_core;
    logic irq_en;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/rtt_rst_sync.sv
module rtt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/rtt_tick_gate.sv
module rtt_tick_gate
  import rtt_pkg::*;
#(
  parameter bit HAS_REF = 1'b1
) (
  input  ctrl_t ctrl_i,
  input  logic  ref_en_i,
  input  logic  halt_i,
  output logic  tick_o
);

  logic src_ok;

  generate
    if (HAS_REF) begin : g_ref
      assign src_ok = ctrl_i.src_core | ref_en_i;
    end else begin : g_core_only
      logic unused_ref;
      assign unused_ref = ref_en_i;
      assign src_ok     = 1'b1;
    end
  endgenerate

  assign tick_o = ctrl_i.run & ~halt_i & src_ok;

endmodule

// File: rtl/rtt_down_counter.sv
module rtt_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             zero_wr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             evt_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cur_q;
  logic [CNT_W-1:0] cur_d;

  always_comb begin
    cur_d = cur_q;
    if (zero_wr_i) begin
      cur_d = '0;
    end else if (tick_i) begin
      if (cur_q == '0) cur_d = reload_i;
      else             cur_d = cur_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  assign evt_o = tick_i & ~zero_wr_i & (cur_q == ONE);
  assign cur_o = cur_q;

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !zero_wr_i && cur_q != '0) |=> (cur_q == $past(cur_q) - ONE));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !zero_wr_i && cur_q == '0) |=> (cur_q == $past(reload_i)));

  assert_write_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_wr_i |=> (cur_q == '0));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !zero_wr_i) |=> $stable(cur_q));

  assert_zero_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == '0 && reload_i == '0) |-> !evt_o);

endmodule

// File: rtl/rtt_regfile.sv
module rtt_regfile
  import rtt_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter int               CNT_W     = 24,
  parameter logic [CNT_W-1:0] CAL_TENMS = CNT_W'(124999),
  parameter bit               CAL_SKEW  = 1'b0,
  parameter bit               CAL_NOREF = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [CNT_W-1:0]      cur_i,
  input  logic                  evt_i,
  output ctrl_t                 ctrl_o,
  output logic [CNT_W-1:0]      reload_o,
  output logic                  zero_wr_o,
  output logic                  flag_o
);

  localparam int HI_W = DATA_W - CNT_W;

  reg_addr_e        addr;
  logic             wr_ctrl, wr_reload, rd_ctrl, rd_en;
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             flag_q, flag_d;
  logic [HI_W-1:0]  unused_wdata_hi;

  assign addr            = reg_addr_e'(bus_addr);
  assign rd_en           = bus_sel & ~bus_wr;
  assign wr_ctrl         = bus_sel & bus_wr & (addr == RA_CTRL);
  assign wr_reload       = bus_sel & bus_wr & (addr == RA_RELOAD);
  assign zero_wr_o       = bus_sel & bus_wr & (addr == RA_CURRENT);
  assign rd_ctrl         = rd_en & (addr == RA_CTRL);
  assign unused_wdata_hi = bus_wdata[DATA_W-1:CNT_W];

  // next state
  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    flag_d   = flag_q;
    if (wr_ctrl) begin
      ctrl_d.run      = bus_wdata[CTRL_RUN_BIT];
      ctrl_d.irq_en   = bus_wdata[CTRL_IE_BIT];
      ctrl_d.src_core = bus_wdata[CTRL_SRC_BIT];
    end
    if (wr_reload) reload_d = bus_wdata[CNT_W-1:0];
    if (evt_i)                     flag_d = 1'b1;
    else if (rd_ctrl || zero_wr_o) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      flag_q   <= flag_d;
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (addr)
        RA_CTRL: begin
          bus_rdata[CTRL_RUN_BIT]  = ctrl_q.run;
          bus_rdata[CTRL_IE_BIT]   = ctrl_q.irq_en;
          bus_rdata[CTRL_SRC_BIT]  = ctrl_q.src_core;
          bus_rdata[CTRL_FLAG_BIT] = flag_q;
        end
        RA_RELOAD:  bus_rdata[CNT_W-1:0] = reload_q;
        RA_CURRENT: bus_rdata[CNT_W-1:0] = cur_i;
        RA_CALIB: begin
          bus_rdata[CNT_W-1:0]    = CAL_TENMS;
          bus_rdata[CAL_SKEW_BIT]  = CAL_SKEW;
          bus_rdata[CAL_NOREF_BIT] = CAL_NOREF;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign flag_o   = flag_q;

  assert_flag_from_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(evt_i));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !evt_i) |=> !flag_q);

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_wr_o |=> !flag_q);

endmodule

// File: rtl/reload_tick_timer.sv
module reload_tick_timer
  import rtt_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter int               CNT_W     = 24,
  parameter bit               HAS_REF   = 1'b1,
  parameter logic [CNT_W-1:0] CAL_TENMS = CNT_W'(124999),
  parameter bit               CAL_SKEW  = 1'b0,
  parameter bit               CAL_NOREF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_en,
  input  logic              halt_req,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req
);

  logic             rst_sync_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cur_val;
  logic             zero_wr, evt, flag, tick;

  rtt_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  rtt_regfile #(
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .CAL_TENMS (CAL_TENMS),
    .CAL_SKEW  (CAL_SKEW),
    .CAL_NOREF (CAL_NOREF)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cur_i     (cur_val),
    .evt_i     (evt),
    .ctrl_o    (ctrl),
    .reload_o  (reload_val),
    .zero_wr_o (zero_wr),
    .flag_o    (flag)
  );

  rtt_tick_gate #(.HAS_REF(HAS_REF)) u_gate (
    .ctrl_i   (ctrl),
    .ref_en_i (ref_tick_en),
    .halt_i   (halt_req),
    .tick_o   (tick)
  );

  rtt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_i    (tick),
    .zero_wr_i (zero_wr),
    .reload_i  (reload_val),
    .cur_o     (cur_val),
    .evt_o     (evt)
  );

  assign irq_req = flag & ctrl.irq_en;

  assert_halt_freezes_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (halt_req && !zero_wr) |=> $stable(cur_val));

endmodule

// File: tb/sim_reload_tick_timer.sv
`timescale 1ns/1ps
module sim_reload_tick_timer;

  localparam logic [1:0]  A_CTRL = 2'd0, A_RELOAD = 2'd1, A_CUR = 2'd2, A_CAL = 2'd3;
  localparam logic [23:0] TENMS  = 24'd124999;
  localparam logic [31:0] CAL_EXP = 32'h4001E847; // skew=1, noref=0

  logic        clk = 1'b0;
  logic        rst_n, ref_tick_en, halt_req, bus_sel, bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_req;

  always #2.5 clk = ~clk;

  reload_tick_timer #(
    .CAL_TENMS (TENMS),
    .CAL_SKEW  (1'b1),
    .CAL_NOREF (1'b0)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .ref_tick_en (ref_tick_en), .halt_req (halt_req),
    .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq_req (irq_req)
  );

  typedef struct { int req; logic [31:0] exp; } exp_t;
  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  task automatic check(int req, logic [31:0] act, logic [31:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic bus_read(logic [1:0] a, logic [31:0] e, int req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    sb_q.push_back('{req, e});
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
    end
  endtask

  task automatic irq_check(logic e, int req);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    #2;
    check(req, 32'(irq_req), 32'(e), "irq_req");
  endtask

  // monitor: pops the scoreboard on every read cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (bus_sel && !bus_wr) begin : mon
        exp_t e;
        if (sb_q.size() == 0) begin
          check(0, 32'd1, 32'd0, "unexpected read");
        end else begin
          e = sb_q.pop_front();
          check(e.req, bus_rdata, e.exp, "read");
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_tick_en = 1'b0; halt_req = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    bus_read(A_CTRL, 32'h0, 1);
    bus_read(A_RELOAD, 32'h0, 1);
    bus_read(A_CUR, 32'h0, 1);
    irq_check(1'b0, 1);

    // R5 zero reload never fires, counter running on core clock
    bus_write(A_CTRL, 32'h7);
    idle(30);
    irq_check(1'b0, 5);
    bus_read(A_CUR, 32'h0, 5);
    bus_read(A_CTRL, 32'h7, 5);

    // R2 reload width
    bus_write(A_RELOAD, 32'hFFFF_FFFF);
    bus_read(A_RELOAD, 32'h00FF_FFFF, 2);

    // R3 period of 10 with reload 9, restarted by a current-value write
    bus_write(A_RELOAD, 32'd9);
    bus_write(A_CUR, 32'hFFFF_FFFF);
    for (int k = 0; k < 25; k++)
      bus_read(A_CUR, (k == 0) ? 32'd0 : 32'(9 - ((k - 1) % 10)), 3);
    // R4 flag and request after the 1-to-0 step
    irq_check(1'b1, 4);
    // R6 first read sees the flag, second sees it cleared
    bus_read(A_CTRL, 32'h0001_0007, 6);
    bus_read(A_CTRL, 32'h0000_0007, 6);
    irq_check(1'b0, 6);
    idle(3);
    irq_check(1'b1, 4);
    // R7 current write drops flag, counter to zero, no event
    bus_write(A_CUR, 32'h1234);
    bus_read(A_CUR, 32'h0, 7);
    bus_read(A_CTRL, 32'h0000_0007, 7);
    irq_check(1'b0, 7);

    // R4 interrupt enable off: flag still sets, request stays low
    bus_write(A_CTRL, 32'h5);
    idle(25);
    irq_check(1'b0, 4);
    bus_read(A_CTRL, 32'h0001_0005, 4);

    // R8 reference source
    bus_write(A_CTRL, 32'h1);
    bus_write(A_CUR, 32'h0);
    idle(8);
    bus_read(A_CUR, 32'h0, 8);
    bus_read(A_CTRL, 32'h1, 8);
    @(negedge clk);
    bus_sel = 1'b0; ref_tick_en = 1'b1;
    @(negedge clk);
    ref_tick_en = 1'b0;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_CUR;
    sb_q.push_back('{8, 32'd9});
    bus_read(A_CUR, 32'd9, 8);

    // R9 halt, R11 flag bit not writable
    @(negedge clk);
    bus_sel = 1'b0; halt_req = 1'b1;
    bus_write(A_CTRL, 32'h0001_0005);
    idle(5);
    bus_read(A_CUR, 32'd9, 9);
    bus_read(A_CTRL, 32'h0000_0005, 11);
    @(negedge clk);
    bus_sel = 1'b0; halt_req = 1'b0;
    bus_read(A_CUR, 32'd8, 9);

    // R10 calibration constant, write ignored
    bus_write(A_CAL, 32'h0);
    bus_read(A_CAL, CAL_EXP, 10);

    idle(3);
    check(0, 32'(sb_q.size()), 32'd0, "scoreboard drained");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule